// File: doc/BRIEF.md
# Cluster Power Reference Controller

This block keeps a presence count for every core of a two-cluster, four-cores-per-cluster processor complex and turns boot, die and kill requests into the power-control sequences for those cores and their clusters. A boot request for a core that is not counted starts a core power-up. If every count in that core's cluster is zero, the core is the first comer, and a cluster power-up runs before the core is started. A die request lowers the count and reports whether a boot request overtook the departing core. A kill request polls the core's standby-WFI status until the core can be switched off. When that core was the last one counted in its cluster, the block waits for the cluster's L2 standby status and then isolates, resets and gates the cluster.

The controller takes one request at a time. All delays are whole clock cycles set by parameters: the settle time after opening or closing a power gate, the poll interval and the maximum number of polls. Requests use a valid/ready pair. Completion is a one-cycle `done` pulse that carries the result flags.

Top module: `cluster_pwr_ref_ctrl`

## Requirements
- R1: After reset the boot core (index 0 by default) has count 1 and every other core has count 0. The boot core's cluster is ungated, out of reset and not isolated, and its boot core is ungated with power-on reset released. Every other core is gated with power-on reset held. Every other cluster is gated, held in reset and isolated. `req_ready` is 1 and `first_comer` is 0.
- R2: A boot request (op code 0) for a core whose count is nonzero adds one to the count, saturating at 3. `done` and `done_ok` go high in the cycle after acceptance, and no power output changes.
- R3: Every accepted boot request loads `first_comer` in the cycle after acceptance. It becomes 1 if every count in the target cluster was zero at acceptance and 0 otherwise.
- R4: Cluster power-up (first comer) runs in this order. One cycle after acceptance, isolation is set, the cluster reset is asserted and every core power-on reset in the cluster is asserted. One cycle later the cluster gate opens. SETTLE_CYC cycles after that the cluster reset is released, and one cycle later isolation is released.
- R5: Core power-up holds the core's power-on reset and then, one cycle later, opens the core gate. SETTLE_CYC cycles later it releases the power-on reset, adds one to the count and pulses `done` with `done_ok`=1. Without a cluster power-up, this sequence starts one cycle after acceptance.
- R6: A die request (op code 1) completes in the cycle after acceptance. If the count was nonzero it is decremented. A resulting count of 1 raises `die_abort`. A resulting count above 1, or a request against a zero count, raises `die_error`. A request against a zero count leaves the count unchanged and sets `done_ok` to 0.
- R7: A kill request (op code 2) checks the core once every POLL_CYC cycles, with the first check POLL_CYC cycles after acceptance. A check succeeds only if the core's count is zero and its WFI input is high. If POLL_LIMIT checks fail, `done` is pulsed with `done_ok`=0 and no output changes.
- R8: On a successful check the core gate closes in the next cycle. SETTLE_CYC cycles after that, if another core of the cluster still has a nonzero count, `done` is pulsed with `done_ok`=1.
- R9: If the killed core was the last one counted, the cluster L2 WFI input is polled the same way. On success, isolation and cluster reset are asserted one cycle after the check, the cluster gate closes one cycle later, and `done` with `done_ok`=1 follows SETTLE_CYC cycles after the gate closes.
- R10: If POLL_LIMIT checks of L2 WFI fail, the cluster stays powered and `done` is pulsed with `done_ok`=1.
- R11: `req_ready` is low from the cycle after a sequence is accepted until its `done` pulse. Requests presented meanwhile are ignored. Op code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 boot, 1 die, 2 kill, 3 ignored |
| req_cpu | input | 3 | Core index: cluster times 4 plus core |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| core_wfi | input | 8 | Per-core standby-WFI status |
| l2_wfi | input | 2 | Per-cluster L2 standby status |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Result of the completed request |
| die_abort | output | 1 | Die request left a count of 1 |
| die_error | output | 1 | Die request found count 0 or left a count above 1 |
| first_comer | output | 1 | Last boot request targeted an empty cluster |
| cl_isolate | output | 2 | Per-cluster snoop/coherency isolation, 1 = isolated |
| cl_gate | output | 2 | Per-cluster power gate, 1 = gated |
| cl_rst_n | output | 2 | Per-cluster debug, bus and L2 reset, active low |
| core_gate | output | 8 | Per-core power gate, 1 = gated |
| core_por_n | output | 8 | Per-core power-on reset, active low |
| core_cnt | output | 16 | Presence counts, 2 bits per core, core 0 in the low bits |

## Verification
A behavioural model in the bench predicts every output in every cycle, so each ordering step and each settle window is checked at the cycle where it should occur. Boot requests cover three cases: an already counted core (count only, including saturation), a new core in a populated cluster (core sequence only) and a core in an empty cluster (cluster sequence first), both from the reset state and after a cluster was left powered. Die requests walk a count down through 3, 2, 1 and 0 and then hit zero again, which exercises the error, abort, normal and underflow results. Kill requests cover a core that is still counted, a core that is not in WFI, a core that is not the last in its cluster, a last core whose L2 never idles and a last core whose L2 idles. A stray request held during a busy sequence must leave the outputs untouched.

// File: rtl/cpr_pkg.sv
// Shared types for the cluster power reference controller.
// Assumes a two-bit request op code on the block's port.
package cpr_pkg;

    typedef enum logic [1:0] {
        OP_BOOT = 2'd0,
        OP_DIE  = 2'd1,
        OP_KILL = 2'd2,
        OP_NONE = 2'd3
    } cpr_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CU_HOLD,
        S_CU_OPEN,
        S_CU_WAIT,
        S_CU_JOIN,
        S_CO_HOLD,
        S_CO_OPEN,
        S_CO_WAIT,
        S_KP,
        S_KD_GATE,
        S_KD_WAIT,
        S_KL,
        S_KC_ISO,
        S_KC_GATE,
        S_KC_WAIT
    } cpr_state_e;

endpackage

// File: rtl/cpr_countdown.sv
// Down-counter shared by settle waits and poll intervals.
// Assumes the loaded value is one less than the wanted cycle count;
// zero is high once the count has run out.
module cpr_countdown #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/cpr_count_bank.sv
// Per-core presence counters with per-cluster emptiness flags.
// Assumes at most one increment or decrement per cycle, both aimed at idx.
// Counts saturate at the top and never go below zero.
module cpr_count_bank #(
    parameter int N_CLUST  = 2,
    parameter int N_CORE   = 4,
    parameter int CNT_W    = 2,
    parameter int BOOT_CPU = 0,
    localparam int N_CPU   = N_CLUST * N_CORE,
    localparam int ID_W    = $clog2(N_CPU)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inc,
    input  logic                   dec,
    input  logic [ID_W-1:0]        idx,
    output logic [N_CPU*CNT_W-1:0] cnt_flat,
    output logic [N_CLUST-1:0]     cl_zero
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar i = 0; i < N_CPU; i++) begin : g_cnt
        logic [CNT_W-1:0] cnt;
        logic             hit;

        assign hit = (int'(idx) == i);

        // Presence count of core i: boot core starts at one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= (i == BOOT_CPU) ? CNT_W'(1) : '0;
            else if (hit && inc && cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
            else if (hit && dec && cnt != '0)
                cnt <= cnt - 1'b1;
        end

        assign cnt_flat[i*CNT_W +: CNT_W] = cnt;

        p_cnt_sat_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (hit && inc && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

        p_no_underflow_r6 : assert property (@(posedge clk) disable iff (!rst_n)
            (hit && dec && cnt == '0) |=> (cnt == '0));
    end

    for (genvar c = 0; c < N_CLUST; c++) begin : g_zero
        assign cl_zero[c] = ~|cnt_flat[c*N_CORE*CNT_W +: N_CORE*CNT_W];
    end

endmodule

// File: rtl/cpr_sequencer.sv
// Request sequencer: accepts one boot, die or kill request at a time and
// drives the cluster and core power controls in a fixed order.
// Assumes N_CORE and N_CLUST are powers of two, so that a core index splits
// into cluster and core fields, and that CNT_W is at least 2.
module cpr_sequencer
    import cpr_pkg::*;
#(
    parameter int N_CLUST    = 2,
    parameter int N_CORE     = 4,
    parameter int CNT_W      = 2,
    parameter int SETTLE_CYC = 20,
    parameter int POLL_CYC   = 10,
    parameter int POLL_LIMIT = 1000,
    parameter int BOOT_CPU   = 0,
    parameter int TMR_W      = 5,
    localparam int N_CPU     = N_CLUST * N_CORE,
    localparam int ID_W      = $clog2(N_CPU),
    localparam int CORE_W    = $clog2(N_CORE),
    localparam int TRY_W     = $clog2(POLL_LIMIT + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [ID_W-1:0]        req_cpu,
    input  logic [N_CPU-1:0]       core_wfi,
    input  logic [N_CLUST-1:0]     l2_wfi,
    input  logic [N_CPU*CNT_W-1:0] cnt_flat,
    input  logic [N_CLUST-1:0]     cl_zero,
    input  logic                   tmr_zero,
    output logic                   tmr_load,
    output logic [TMR_W-1:0]       tmr_val,
    output logic                   cnt_inc,
    output logic                   cnt_dec,
    output logic [ID_W-1:0]        cnt_idx,
    output logic                   req_ready,
    output logic                   done,
    output logic                   done_ok,
    output logic                   die_abort,
    output logic                   die_error,
    output logic                   first_comer,
    output logic [N_CLUST-1:0]     cl_isolate,
    output logic [N_CLUST-1:0]     cl_gate,
    output logic [N_CLUST-1:0]     cl_rst_n,
    output logic [N_CPU-1:0]       core_gate,
    output logic [N_CPU-1:0]       core_por_n
);

    localparam int                 BOOT_CL = BOOT_CPU / N_CORE;
    localparam logic [TMR_W-1:0]   SET_V   = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0]   POLL_V  = TMR_W'(POLL_CYC - 1);
    localparam logic [TRY_W-1:0]   LAST_T  = TRY_W'(POLL_LIMIT - 1);

    cpr_state_e       st, nxt;
    cpr_op_e          op;
    logic [ID_W-1:0]  tgt;
    logic [TRY_W-1:0] tries;
    logic [CNT_W-1:0] req_cnt, tgt_cnt;
    int               req_cl, tgt_cl;
    logic             last_try;
    logic             seen;

    assign op       = cpr_op_e'(req_op);
    assign req_cl   = int'(req_cpu) >> CORE_W;
    assign tgt_cl   = int'(tgt) >> CORE_W;
    assign req_cnt  = cnt_flat[int'(req_cpu)*CNT_W +: CNT_W];
    assign tgt_cnt  = cnt_flat[int'(tgt)*CNT_W +: CNT_W];
    assign last_try = (tries == LAST_T);
    assign req_ready = (st == S_IDLE);

    // Next state, timer loads and counter strobes.
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cnt_inc  = 1'b0;
        cnt_dec  = 1'b0;
        cnt_idx  = tgt;
        unique case (st)
            S_IDLE: begin
                cnt_idx = req_cpu;
                if (req_valid) begin
                    case (op)
                        OP_BOOT: begin
                            if (req_cnt != '0)
                                cnt_inc = 1'b1;
                            else
                                nxt = cl_zero[req_cl] ? S_CU_HOLD : S_CO_HOLD;
                        end
                        OP_DIE:  cnt_dec = (req_cnt != '0);
                        OP_KILL: begin
                            nxt      = S_KP;
                            tmr_load = 1'b1;
                            tmr_val  = POLL_V;
                        end
                        default: ;
                    endcase
                end
            end
            S_CU_HOLD: nxt = S_CU_OPEN;
            S_CU_OPEN: begin
                tmr_load = 1'b1;
                tmr_val  = SET_V;
                nxt      = S_CU_WAIT;
            end
            S_CU_WAIT: if (tmr_zero) nxt = S_CU_JOIN;
            S_CU_JOIN: nxt = S_CO_HOLD;
            S_CO_HOLD: nxt = S_CO_OPEN;
            S_CO_OPEN: begin
                tmr_load = 1'b1;
                tmr_val  = SET_V;
                nxt      = S_CO_WAIT;
            end
            S_CO_WAIT: begin
                if (tmr_zero) begin
                    cnt_inc = 1'b1;
                    nxt     = S_IDLE;
                end
            end
            S_KP: begin
                if (tmr_zero) begin
                    if (tgt_cnt == '0 && core_wfi[tgt])
                        nxt = S_KD_GATE;
                    else if (last_try)
                        nxt = S_IDLE;
                    else begin
                        tmr_load = 1'b1;
                        tmr_val  = POLL_V;
                    end
                end
            end
            S_KD_GATE: begin
                tmr_load = 1'b1;
                tmr_val  = SET_V;
                nxt      = S_KD_WAIT;
            end
            S_KD_WAIT: begin
                if (tmr_zero) begin
                    if (cl_zero[tgt_cl]) begin
                        nxt      = S_KL;
                        tmr_load = 1'b1;
                        tmr_val  = POLL_V;
                    end else
                        nxt = S_IDLE;
                end
            end
            S_KL: begin
                if (tmr_zero) begin
                    if (l2_wfi[tgt_cl])
                        nxt = S_KC_ISO;
                    else if (last_try)
                        nxt = S_IDLE;
                    else begin
                        tmr_load = 1'b1;
                        tmr_val  = POLL_V;
                    end
                end
            end
            S_KC_ISO:  nxt = S_KC_GATE;
            S_KC_GATE: begin
                tmr_load = 1'b1;
                tmr_val  = SET_V;
                nxt      = S_KC_WAIT;
            end
            S_KC_WAIT: if (tmr_zero) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // State, target, poll count, result pulses and power control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            tgt         <= '0;
            tries       <= '0;
            done        <= 1'b0;
            done_ok     <= 1'b0;
            die_abort   <= 1'b0;
            die_error   <= 1'b0;
            first_comer <= 1'b0;
            for (int c = 0; c < N_CLUST; c++) begin
                cl_isolate[c] <= (c != BOOT_CL);
                cl_gate[c]    <= (c != BOOT_CL);
                cl_rst_n[c]   <= (c == BOOT_CL);
            end
            for (int i = 0; i < N_CPU; i++) begin
                core_gate[i]  <= (i != BOOT_CPU);
                core_por_n[i] <= (i == BOOT_CPU);
            end
        end else begin
            st        <= nxt;
            done      <= 1'b0;
            done_ok   <= 1'b0;
            die_abort <= 1'b0;
            die_error <= 1'b0;
            if (st != S_IDLE && nxt == S_IDLE) begin
                done    <= 1'b1;
                done_ok <= (st != S_KP);
            end
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        tgt   <= req_cpu;
                        tries <= '0;
                        if (op == OP_BOOT) begin
                            first_comer <= cl_zero[req_cl];
                            if (req_cnt != '0) begin
                                done    <= 1'b1;
                                done_ok <= 1'b1;
                            end
                        end
                        if (op == OP_DIE) begin
                            done      <= 1'b1;
                            done_ok   <= (req_cnt != '0);
                            die_abort <= (req_cnt == CNT_W'(2));
                            die_error <= (req_cnt == '0) || (req_cnt > CNT_W'(2));
                        end
                    end
                end
                S_CU_HOLD: begin
                    cl_isolate[tgt_cl] <= 1'b1;
                    cl_rst_n[tgt_cl]   <= 1'b0;
                    core_por_n[tgt_cl*N_CORE +: N_CORE] <= '0;
                end
                S_CU_OPEN: cl_gate[tgt_cl] <= 1'b0;
                S_CU_WAIT: if (tmr_zero) cl_rst_n[tgt_cl] <= 1'b1;
                S_CU_JOIN: cl_isolate[tgt_cl] <= 1'b0;
                S_CO_HOLD: core_por_n[tgt] <= 1'b0;
                S_CO_OPEN: core_gate[tgt] <= 1'b0;
                S_CO_WAIT: if (tmr_zero) core_por_n[tgt] <= 1'b1;
                S_KP:      if (tmr_zero) tries <= tries + 1'b1;
                S_KD_GATE: core_gate[tgt] <= 1'b1;
                S_KD_WAIT: if (tmr_zero) tries <= '0;
                S_KL:      if (tmr_zero) tries <= tries + 1'b1;
                S_KC_ISO: begin
                    cl_isolate[tgt_cl] <= 1'b1;
                    cl_rst_n[tgt_cl]   <= 1'b0;
                end
                S_KC_GATE: cl_gate[tgt_cl] <= 1'b1;
                default: ;
            endcase
        end
    end

    // Marks the first cycle that has a reset-time history behind it.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    for (genvar c = 0; c < N_CLUST; c++) begin : g_cl_chk
        p_rst_rel_gated_r4 : assert property (@(posedge clk) disable iff (!rst_n || !seen)
            $rose(cl_rst_n[c]) |-> (!cl_gate[c] && cl_isolate[c]));
        p_iso_rel_last_r4 : assert property (@(posedge clk) disable iff (!rst_n || !seen)
            $fell(cl_isolate[c]) |-> (cl_rst_n[c] && !cl_gate[c]));
        p_gate_after_rst_r9 : assert property (@(posedge clk) disable iff (!rst_n || !seen)
            $rose(cl_gate[c]) |-> (!cl_rst_n[c] && cl_isolate[c]));
    end

    for (genvar i = 0; i < N_CPU; i++) begin : g_core_chk
        p_core_open_r5 : assert property (@(posedge clk) disable iff (!rst_n || !seen)
            $fell(core_gate[i]) |-> (!core_por_n[i] && !cl_gate[i / N_CORE]));
        p_por_rel_r5 : assert property (@(posedge clk) disable iff (!rst_n || !seen)
            $rose(core_por_n[i]) |-> !core_gate[i]);
    end

    p_done_idle_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    p_die_excl_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        !(die_abort && die_error));

    p_die_done_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (die_abort || die_error) |-> done);

endmodule

// File: rtl/cluster_pwr_ref_ctrl.sv
// Cluster power reference controller top: joins the presence counters,
// the shared countdown timer and the request sequencer.
// Assumes N_CLUST and N_CORE are powers of two and CNT_W is at least 2.
module cluster_pwr_ref_ctrl #(
    parameter int N_CLUST    = 2,
    parameter int N_CORE     = 4,
    parameter int CNT_W      = 2,
    parameter int SETTLE_CYC = 20,
    parameter int POLL_CYC   = 10,
    parameter int POLL_LIMIT = 1000,
    parameter int BOOT_CPU   = 0,
    localparam int N_CPU     = N_CLUST * N_CORE,
    localparam int ID_W      = $clog2(N_CPU),
    localparam int TMR_MAX   = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC,
    localparam int TMR_W     = $clog2(TMR_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [ID_W-1:0]        req_cpu,
    output logic                   req_ready,
    input  logic [N_CPU-1:0]       core_wfi,
    input  logic [N_CLUST-1:0]     l2_wfi,
    output logic                   done,
    output logic                   done_ok,
    output logic                   die_abort,
    output logic                   die_error,
    output logic                   first_comer,
    output logic [N_CLUST-1:0]     cl_isolate,
    output logic [N_CLUST-1:0]     cl_gate,
    output logic [N_CLUST-1:0]     cl_rst_n,
    output logic [N_CPU-1:0]       core_gate,
    output logic [N_CPU-1:0]       core_por_n,
    output logic [N_CPU*CNT_W-1:0] core_cnt
);

    logic               tmr_load, tmr_zero;
    logic [TMR_W-1:0]   tmr_val;
    logic               cnt_inc, cnt_dec;
    logic [ID_W-1:0]    cnt_idx;
    logic [N_CLUST-1:0] cl_zero;

    cpr_count_bank #(
        .N_CLUST (N_CLUST),
        .N_CORE  (N_CORE),
        .CNT_W   (CNT_W),
        .BOOT_CPU(BOOT_CPU)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (cnt_inc),
        .dec     (cnt_dec),
        .idx     (cnt_idx),
        .cnt_flat(core_cnt),
        .cl_zero (cl_zero)
    );

    cpr_countdown #(
        .W(TMR_W)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    cpr_sequencer #(
        .N_CLUST   (N_CLUST),
        .N_CORE    (N_CORE),
        .CNT_W     (CNT_W),
        .SETTLE_CYC(SETTLE_CYC),
        .POLL_CYC  (POLL_CYC),
        .POLL_LIMIT(POLL_LIMIT),
        .BOOT_CPU  (BOOT_CPU),
        .TMR_W     (TMR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_cpu    (req_cpu),
        .core_wfi   (core_wfi),
        .l2_wfi     (l2_wfi),
        .cnt_flat   (core_cnt),
        .cl_zero    (cl_zero),
        .tmr_zero   (tmr_zero),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .cnt_inc    (cnt_inc),
        .cnt_dec    (cnt_dec),
        .cnt_idx    (cnt_idx),
        .req_ready  (req_ready),
        .done       (done),
        .done_ok    (done_ok),
        .die_abort  (die_abort),
        .die_error  (die_error),
        .first_comer(first_comer),
        .cl_isolate (cl_isolate),
        .cl_gate    (cl_gate),
        .cl_rst_n   (cl_rst_n),
        .core_gate  (core_gate),
        .core_por_n (core_por_n)
    );

endmodule

// File: tb/sim_cluster_pwr_ref_ctrl.sv
// Bench: a behavioural model steps alongside the design and every output
// is compared once per clock, a quarter period after the rising edge.
module sim_cluster_pwr_ref_ctrl;

    localparam int CLK_P = 10;
    localparam int S     = 4;
    localparam int P     = 3;
    localparam int LIM   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd3;
    logic [2:0] req_cpu = '0;
    logic [7:0] core_wfi = '0;
    logic [1:0] l2_wfi = '0;
    logic       req_ready, done, done_ok, die_abort, die_error, first_comer;
    logic [1:0] cl_isolate, cl_gate, cl_rst_n;
    logic [7:0] core_gate, core_por_n;
    logic [15:0] core_cnt;

    // Model state.
    int         mcnt [8];
    logic       e_ready, e_done, e_ok, e_abort, e_err, e_first;
    logic [1:0] e_iso, e_gate, e_rn;
    logic [7:0] e_cg, e_por;
    string      cur_req;
    int         tests = 0;
    int         fails = 0;

    always #(CLK_P/2) clk = ~clk;

    cluster_pwr_ref_ctrl #(
        .SETTLE_CYC(S),
        .POLL_CYC  (P),
        .POLL_LIMIT(LIM)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_cpu(req_cpu), .req_ready(req_ready), .core_wfi(core_wfi),
        .l2_wfi(l2_wfi), .done(done), .done_ok(done_ok), .die_abort(die_abort),
        .die_error(die_error), .first_comer(first_comer), .cl_isolate(cl_isolate),
        .cl_gate(cl_gate), .cl_rst_n(cl_rst_n), .core_gate(core_gate),
        .core_por_n(core_por_n), .core_cnt(core_cnt)
    );

    // Compares every output with the model's prediction.
    task automatic check_all();
        logic [15:0] ec;
        logic [43:0] act, exp;
        for (int i = 0; i < 8; i++) ec[i*2 +: 2] = 2'(mcnt[i]);
        act = {req_ready, done, done_ok, die_abort, die_error, first_comer,
               cl_isolate, cl_gate, cl_rst_n, core_gate, core_por_n, core_cnt};
        exp = {e_ready, e_done, e_ok, e_abort, e_err, e_first,
               e_iso, e_gate, e_rn, e_cg, e_por, ec};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%h expected=%h", cur_req, $time, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #(CLK_P/4);
        check_all();
    endtask

    task automatic clr_pulse();
        e_done = 1'b0; e_ok = 1'b0; e_abort = 1'b0; e_err = 1'b0;
    endtask

    task automatic finish_ok(input logic ok);
        e_done = 1'b1; e_ok = ok; e_ready = 1'b1;
        cyc();
        clr_pulse();
    endtask

    task automatic send(input logic [1:0] op, input int cpu);
        req_valid = 1'b1; req_op = op; req_cpu = 3'(cpu);
    endtask

    function automatic logic cl_empty(input int cl);
        for (int k = 0; k < 4; k++) if (mcnt[cl*4+k] != 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic boot(input int cpu);
        int  cl = cpu / 4;
        logic zero = cl_empty(cl);
        send(2'd0, cpu);
        e_first = zero;
        if (mcnt[cpu] != 0) begin
            cur_req = "R2";
            e_done = 1'b1; e_ok = 1'b1;
            if (mcnt[cpu] < 3) mcnt[cpu]++;
            cyc();
            req_valid = 1'b0;
            clr_pulse();
            return;
        end
        cur_req = "R3";
        e_ready = 1'b0;
        cyc();
        req_valid = 1'b0;
        if (zero) begin
            cur_req = "R4";
            e_iso[cl] = 1'b1; e_rn[cl] = 1'b0;
            for (int k = 0; k < 4; k++) e_por[cl*4+k] = 1'b0;
            cyc();
            e_gate[cl] = 1'b0;
            cyc();
            repeat (S-1) cyc();
            e_rn[cl] = 1'b1;
            cyc();
            e_iso[cl] = 1'b0;
            cyc();
        end
        cur_req = "R5";
        e_por[cpu] = 1'b0;
        cyc();
        e_cg[cpu] = 1'b0;
        cyc();
        repeat (S-1) cyc();
        e_por[cpu] = 1'b1;
        mcnt[cpu]++;
        finish_ok(1'b1);
    endtask

    task automatic die(input int cpu);
        int c = mcnt[cpu];
        cur_req = "R6";
        send(2'd1, cpu);
        e_done = 1'b1; e_ok = (c != 0); e_abort = (c == 2); e_err = (c == 0) || (c > 2);
        if (c != 0) mcnt[cpu]--;
        cyc();
        req_valid = 1'b0;
        clr_pulse();
    endtask

    task automatic kill(input int cpu, input logic noisy);
        int  cl = cpu / 4;
        logic cok = (mcnt[cpu] == 0) && core_wfi[cpu];
        send(2'd2, cpu);
        cur_req = "R7";
        e_ready = 1'b0;
        cyc();
        req_valid = 1'b0;
        if (!cok) begin
            for (int i = 1; i < LIM*P; i++) begin
                if (noisy && i == 2) begin
                    cur_req = "R11";
                    send(2'd0, 5);
                end
                if (noisy && i == 5) req_valid = 1'b0;
                cyc();
            end
            finish_ok(1'b0);
            return;
        end
        repeat (P) cyc();
        cur_req = "R8";
        e_cg[cpu] = 1'b1;
        cyc();
        repeat (S-1) cyc();
        if (!cl_empty(cl)) begin
            finish_ok(1'b1);
            return;
        end
        cyc();
        if (!l2_wfi[cl]) begin
            cur_req = "R10";
            repeat (LIM*P - 1) cyc();
            finish_ok(1'b1);
            return;
        end
        cur_req = "R9";
        repeat (P) cyc();
        e_iso[cl] = 1'b1; e_rn[cl] = 1'b0;
        cyc();
        e_gate[cl] = 1'b1;
        cyc();
        repeat (S-1) cyc();
        finish_ok(1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mcnt[i] = 0;
        mcnt[0] = 1;
        e_ready = 1'b1; e_first = 1'b0;
        clr_pulse();
        e_iso = 2'b10; e_gate = 2'b10; e_rn = 2'b01;
        e_cg = 8'hFE; e_por = 8'h01;
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        cyc();

        boot(0);              // R2 count 1 -> 2
        die(0);               // R6 abort, 2 -> 1
        boot(1);              // R3 first 0, R5 core-only sequence
        boot(4);              // R3 first 1, R4 then R5
        boot(4);              // R2 2
        boot(4);              // R2 3
        boot(4);              // R2 saturation at 3
        die(4);               // R6 error, 3 -> 2
        die(4);               // R6 abort, 2 -> 1
        die(4);               // R6 normal, 1 -> 0
        die(6);               // R6 zero count, error, unchanged

        cur_req = "R11";      // op code 3 ignored
        send(2'd3, 2);
        cyc();
        req_valid = 1'b0;
        cyc();

        kill(1, 1'b1);        // R7 count still 1, R11 stray request
        kill(6, 1'b0);        // R7 count 0 but no WFI
        die(1);
        core_wfi[1] = 1'b1;
        kill(1, 1'b0);        // R8 core down, cluster keeps core 0
        core_wfi[4] = 1'b1;
        kill(4, 1'b0);        // R10 last man, L2 never idle
        boot(4);              // R4 cluster up again after timeout
        die(4);
        l2_wfi[1] = 1'b1;
        kill(4, 1'b0);        // R9 full cluster power-down
        boot(4);              // R4 from a gated cluster
        repeat (2) cyc();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule